// File: doc/BRIEF.md
# SPI master controller

A single-channel SPI master for a system bus. Software writes a 16-bit configuration word that picks the serial clock divider, the bit order, the active level of chip select, the idle level of the serial clock, whether data is launched and captured on the same clock edge or on opposite edges, a stream mode, enable, interrupt enable, and which of two pin sets carries the traffic: an external port or an internal port wired to an on-chip target. Writing a byte to the data register starts one full-duplex exchange. The shift engine sends the byte on MOSI while it collects a byte from MISO. Reading the data register afterwards returns the collected byte.

Every byte takes 17 half periods of the serial clock. The first half period is a setup time after chip select asserts. Then come eight clock pulses. The last half period is a hold tail before chip select can drop. With stream mode set, chip select stays asserted after the byte. Later bytes then continue the same transaction, which ends only when software clears the stream bit. At the end of each byte the block can raise a one-cycle interrupt.

Top module: `spi_master_ctl`

## Requirements
- R1: After reset the configuration reads 0x0002 (divider 2, everything else off). `busy` and `irq` are low. Both chip-select pins sit at their inactive level (high, since active-low is the reset sense). Both serial clocks and both MOSI pins are low.
- R2: A data write while bit 13 (enable) is set and `busy` is low starts a byte. `busy` is high from the next cycle for exactly 17·P cycles, where P is bits 7:0 of the configuration and a value of 0 counts as 1.
- R3: The written byte appears on MOSI, and after `busy` falls `dat_rdata` holds the byte sampled from MISO. Bit 8 = 0 sends and receives the most significant bit first. Bit 8 = 1 sends and receives the least significant bit first.
- R4: Bit 11 = 0: MISO is captured on each leading clock edge and MOSI moves on each trailing edge. Bit 11 = 1: MOSI moves on the same leading edge that captures MISO.
- R5: The serial clock idles at the level of bit 10. Each byte makes exactly 8 leading edges (away from the idle level) and 8 trailing edges, and the clock is back at idle when `busy` falls.
- R6: Chip select is at its active level for the whole time `busy` is high. The active level is high when bit 9 = 1 and low when bit 9 = 0.
- R7: With bit 12 (stream) set, chip select stays active after the byte ends and across idle cycles until the next byte. Clearing bit 12 returns it to the inactive level by the second clock edge after the configuration write.
- R8: A data write while `busy` is high is ignored: the byte in flight, its timing and the received result are unchanged.
- R9: A data write while bit 13 is clear starts nothing. Clearing bit 13 during a byte stops it by the second clock edge after the write, with no interrupt.
- R10: When bit 14 is set, `irq` is high for exactly one cycle, the cycle in which `busy` has just fallen after a completed byte. When bit 14 is clear, `irq` stays low.
- R11: Bit 15 = 1 drives the internal port and takes MISO from it. Bit 15 = 0 does the same with the external port. The unselected port holds chip select inactive, its clock at the idle level and MOSI low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 16 | Configuration write value |
| cfg_rdata | output | 16 | Current configuration |
| dat_we | input | 1 | Data write strobe (starts a byte) |
| dat_wdata | input | 8 | Byte to send |
| dat_rdata | output | 8 | Last received byte |
| busy | output | 1 | Byte in progress |
| irq | output | 1 | One-cycle end-of-byte interrupt |
| ext_sclk | output | 1 | External port serial clock |
| ext_cs | output | 1 | External port chip select |
| ext_mosi | output | 1 | External port data out |
| ext_miso | input | 1 | External port data in |
| int_sclk | output | 1 | Internal port serial clock |
| int_cs | output | 1 | Internal port chip select |
| int_mosi | output | 1 | Internal port data out |
| int_miso | input | 1 | Internal port data in |

## Verification
Call the rising edge that accepts a data write W. `busy` and chip select change just after W. The k-th serial clock edge comes right after edge W+k·P, for k = 1 to 16. `busy` falls, `irq` pulses and `dat_rdata` updates just after W+17·P. The bench samples on the falling clock edge after each rising edge W+j and compares `busy` against j < 17·P and `irq` against j = 17·P. It then checks the received byte, the slave's view of MOSI and the edge counts only once that cycle has passed. Configuration writes land one edge after the strobe. Stream release and abort are therefore checked two edges after the write.

// File: rtl/spi_mst_pkg.sv
package spi_mst_pkg;

   localparam int CFG_W   = 16;
   localparam int PRESC_W = 8;

   typedef struct packed {
      logic               route_int;
      logic               irq_en;
      logic               en;
      logic               stream;
      logic               same_edge;
      logic               ck_inv;
      logic               cs_hi;
      logic               lsb_first;
      logic [PRESC_W-1:0] presc;
   } cfg_t;

   localparam logic [CFG_W-1:0] CFG_RST = 16'h0002;

   localparam int PORT_EXT = 0;
   localparam int PORT_INT = 1;
   localparam int NPORT    = 2;

endpackage

// File: rtl/spi_mst_clkgen.sv
module spi_mst_clkgen #(
   parameter int PRESC_W = 8
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               start,
   input  logic               run,
   input  logic [PRESC_W-1:0] presc,
   output logic               tick
);

   if (PRESC_W < 1 || PRESC_W > 16) begin : g_bad_presc
      $error("spi_mst_clkgen: PRESC_W out of range");
   end

   logic [PRESC_W-1:0] cnt_q;
   logic [PRESC_W-1:0] lim_q;
   logic [PRESC_W-1:0] lim_d;

   assign lim_d = (presc == '0) ? PRESC_W'(1) : presc;
   assign tick  = run && (cnt_q == lim_q - PRESC_W'(1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
         lim_q <= PRESC_W'(1);
      end else if (start) begin
         cnt_q <= '0;
         lim_q <= lim_d;
      end else if (run) begin
         cnt_q <= tick ? '0 : cnt_q + PRESC_W'(1);
      end else begin
         cnt_q <= '0;
      end
   end

   AST_TICK_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && lim_q != PRESC_W'(1)) |=> !tick); // R2

endmodule

// File: rtl/spi_mst_shifter.sv
module spi_mst_shifter #(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic              abort,
   input  logic              tick,
   input  logic [DATA_W-1:0] tx_data,
   input  logic              lsb_first,
   input  logic              same_edge,
   input  logic              miso,
   output logic              busy,
   output logic              sclk_nom,
   output logic              mosi,
   output logic              fin,
   output logic              done,
   output logic [DATA_W-1:0] rx_data
);

   localparam int HALVES = 2 * DATA_W;
   localparam int HC_W   = $clog2(HALVES + 1);
   localparam logic [HC_W-1:0] LAST_HALF = HC_W'(HALVES);

   if (DATA_W < 2 || DATA_W > 32) begin : g_bad_width
      $error("spi_mst_shifter: DATA_W out of range");
   end

   logic [DATA_W-1:0] sh_q;
   logic [DATA_W-1:0] rx_q;
   logic [DATA_W-1:0] tx_rev;
   logic [DATA_W-1:0] sh_rev;
   logic [HC_W-1:0]   half_q;
   logic              busy_q, sclk_q, cap_q, lsb_q, same_q, done_q;

   for (genvar i = 0; i < DATA_W; i++) begin : g_rev
      assign tx_rev[i] = tx_data[DATA_W-1-i];
      assign sh_rev[i] = sh_q[DATA_W-1-i];
   end

   assign fin      = busy_q && tick && (half_q == LAST_HALF) && !abort;
   assign busy     = busy_q;
   assign sclk_nom = sclk_q;
   assign mosi     = busy_q & sh_q[DATA_W-1];
   assign done     = done_q;
   assign rx_data  = rx_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sh_q   <= '0;
         rx_q   <= '0;
         half_q <= '0;
         busy_q <= 1'b0;
         sclk_q <= 1'b0;
         cap_q  <= 1'b0;
         lsb_q  <= 1'b0;
         same_q <= 1'b0;
         done_q <= 1'b0;
      end else begin
         done_q <= 1'b0;
         if (abort) begin
            busy_q <= 1'b0;
            sclk_q <= 1'b0;
         end else if (start) begin
            busy_q <= 1'b1;
            sh_q   <= lsb_first ? tx_rev : tx_data;
            lsb_q  <= lsb_first;
            same_q <= same_edge;
            half_q <= '0;
            sclk_q <= 1'b0;
            cap_q  <= 1'b0;
         end else if (busy_q && tick) begin
            if (half_q == LAST_HALF) begin
               busy_q <= 1'b0;
               done_q <= 1'b1;
               rx_q   <= lsb_q ? sh_rev : sh_q;
            end else begin
               sclk_q <= ~sclk_q;
               if (!half_q[0]) begin
                  if (same_q) sh_q <= {sh_q[DATA_W-2:0], miso};
                  else        cap_q <= miso;
               end else if (!same_q) begin
                  sh_q <= {sh_q[DATA_W-2:0], cap_q};
               end
            end
            half_q <= half_q + HC_W'(1);
         end
      end
   end

   AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      done_q |=> !done_q); // R10
   AST_IDLE_SCLK: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy_q) |-> !sclk_q); // R5
   AST_NO_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
      start |-> !busy_q); // R8

endmodule

// File: rtl/spi_mst_csctl.sv
module spi_mst_csctl (
   input  logic clk,
   input  logic rst_n,
   input  logic busy,
   input  logic fin,
   input  logic stream,
   input  logic en,
   output logic cs_act
);

   logic held_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) held_q <= 1'b0;
      else        held_q <= en & stream & (held_q | fin);
   end

   assign cs_act = busy | held_q;

   AST_CS_COVERS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> cs_act); // R6
   AST_HOLD_NEEDS_STREAM: assert property (@(posedge clk) disable iff (!rst_n)
      (cs_act && !busy) |-> $past(stream)); // R7

endmodule

// File: rtl/spi_master_ctl.sv
module spi_master_ctl
   import spi_mst_pkg::*;
#(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_we,
   input  logic [CFG_W-1:0]  cfg_wdata,
   output logic [CFG_W-1:0]  cfg_rdata,
   input  logic              dat_we,
   input  logic [DATA_W-1:0] dat_wdata,
   output logic [DATA_W-1:0] dat_rdata,
   output logic              busy,
   output logic              irq,
   output logic              ext_sclk,
   output logic              ext_cs,
   output logic              ext_mosi,
   input  logic              ext_miso,
   output logic              int_sclk,
   output logic              int_cs,
   output logic              int_mosi,
   input  logic              int_miso
);

   if ($bits(cfg_t) != CFG_W) begin : g_bad_cfg
      $error("spi_master_ctl: configuration layout does not fill the register");
   end

   cfg_t cfg_q;
   logic start, abort, tick, fin, done;
   logic busy_w, sclk_nom, mosi_nom, cs_act, miso_sel;
   logic [NPORT-1:0] p_sel, pin_sclk, pin_cs, pin_mosi;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      cfg_q <= cfg_t'(CFG_RST);
      else if (cfg_we) cfg_q <= cfg_t'(cfg_wdata);
   end

   assign start = dat_we & cfg_q.en & ~busy_w;
   assign abort = busy_w & ~cfg_q.en;

   spi_mst_clkgen #(.PRESC_W(PRESC_W)) u_clk (
      .clk   (clk),
      .rst_n (rst_n),
      .start (start),
      .run   (busy_w),
      .presc (cfg_q.presc),
      .tick  (tick)
   );

   spi_mst_shifter #(.DATA_W(DATA_W)) u_shift (
      .clk       (clk),
      .rst_n     (rst_n),
      .start     (start),
      .abort     (abort),
      .tick      (tick),
      .tx_data   (dat_wdata),
      .lsb_first (cfg_q.lsb_first),
      .same_edge (cfg_q.same_edge),
      .miso      (miso_sel),
      .busy      (busy_w),
      .sclk_nom  (sclk_nom),
      .mosi      (mosi_nom),
      .fin       (fin),
      .done      (done),
      .rx_data   (dat_rdata)
   );

   spi_mst_csctl u_cs (
      .clk    (clk),
      .rst_n  (rst_n),
      .busy   (busy_w),
      .fin    (fin),
      .stream (cfg_q.stream),
      .en     (cfg_q.en),
      .cs_act (cs_act)
   );

   assign p_sel[PORT_EXT] = ~cfg_q.route_int;
   assign p_sel[PORT_INT] =  cfg_q.route_int;

   for (genvar i = 0; i < NPORT; i++) begin : g_port
      assign pin_sclk[i] = p_sel[i] ? (sclk_nom ^ cfg_q.ck_inv) : cfg_q.ck_inv;
      assign pin_cs[i]   = (p_sel[i] & cs_act) ? cfg_q.cs_hi : ~cfg_q.cs_hi;
      assign pin_mosi[i] = p_sel[i] & mosi_nom;
   end

   assign miso_sel  = cfg_q.route_int ? int_miso : ext_miso;
   assign ext_sclk  = pin_sclk[PORT_EXT];
   assign ext_cs    = pin_cs[PORT_EXT];
   assign ext_mosi  = pin_mosi[PORT_EXT];
   assign int_sclk  = pin_sclk[PORT_INT];
   assign int_cs    = pin_cs[PORT_INT];
   assign int_mosi  = pin_mosi[PORT_INT];
   assign cfg_rdata = cfg_q;
   assign busy      = busy_w;
   assign irq       = done & cfg_q.irq_en;

   AST_START_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      (dat_we && cfg_q.en && !busy_w) |=> busy_w); // R2
   AST_DISABLED_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      !cfg_q.en |=> !busy_w); // R9
   AST_IRQ_AT_FALL: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> (!busy_w && $past(busy_w))); // R10

endmodule

// File: tb/sim_spi_master_ctl.sv
`timescale 1ns/1ps
module sim_spi_master_ctl;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_we = 1'b0;
   logic [15:0] cfg_wdata = '0;
   logic [15:0] cfg_rdata;
   logic        dat_we = 1'b0;
   logic [7:0]  dat_wdata = '0;
   logic [7:0]  dat_rdata;
   logic        busy, irq;
   logic        ext_sclk, ext_cs, ext_mosi, ext_miso;
   logic        int_sclk, int_cs, int_mosi, int_miso;

   always #2.5 clk = ~clk;

   spi_master_ctl u0 (
      .clk(clk), .rst_n(rst_n),
      .cfg_we(cfg_we), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
      .dat_we(dat_we), .dat_wdata(dat_wdata), .dat_rdata(dat_rdata),
      .busy(busy), .irq(irq),
      .ext_sclk(ext_sclk), .ext_cs(ext_cs), .ext_mosi(ext_mosi), .ext_miso(ext_miso),
      .int_sclk(int_sclk), .int_cs(int_cs), .int_mosi(int_mosi), .int_miso(int_miso)
   );

   int n_chk = 0;
   int n_fail = 0;

   // bench copy of the configuration fields
   int cur_p = 2;
   bit cur_order = 0, cur_cshi = 0, cur_inv = 0, cur_mode = 0;
   bit cur_stream = 0, cur_en = 0, cur_ien = 0, cur_route = 0;

   // slave model
   logic [7:0] s_tx = '0;
   logic [7:0] s_rx;
   bit s_clr = 0;
   int s_idx, s_rcnt, s_lead, s_trail;
   bit s_prev, s_mprev;
   logic miso_b;
   logic sel_sclk, sel_cs, sel_mosi, oth_sclk, oth_cs, oth_mosi;

   assign sel_sclk = cur_route ? int_sclk : ext_sclk;
   assign sel_cs   = cur_route ? int_cs   : ext_cs;
   assign sel_mosi = cur_route ? int_mosi : ext_mosi;
   assign oth_sclk = cur_route ? ext_sclk : int_sclk;
   assign oth_cs   = cur_route ? ext_cs   : int_cs;
   assign oth_mosi = cur_route ? ext_mosi : int_mosi;

   always_comb begin
      if (s_idx < 8) miso_b = cur_order ? s_tx[s_idx] : s_tx[7 - s_idx];
      else           miso_b = 1'b0;
   end
   assign int_miso = cur_route ? miso_b : 1'b1;
   assign ext_miso = cur_route ? 1'b1 : miso_b;

   always @(negedge clk) begin
      bit now;
      now = sel_sclk ^ cur_inv;
      if (s_clr) begin
         s_idx = 0; s_rcnt = 0; s_lead = 0; s_trail = 0; s_rx = '0;
      end else begin
         if (!s_prev && now) begin
            s_lead++;
            if (s_rcnt < 8) begin
               if (cur_order) s_rx[s_rcnt] = s_mprev;
               else           s_rx[7 - s_rcnt] = s_mprev;
               s_rcnt++;
            end
            if (cur_mode) s_idx++;
         end
         if (s_prev && !now) begin
            s_trail++;
            if (!cur_mode) s_idx++;
         end
      end
      s_prev  = now;
      s_mprev = sel_mosi;
   end

   task automatic chk(input bit ok, input string req, input string what,
                      input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   task automatic set_cfg(input logic [15:0] v);
      @(negedge clk);
      cfg_we = 1'b1; cfg_wdata = v;
      @(negedge clk);
      cfg_we = 1'b0;
      @(posedge clk);
      cur_p = int'(v[7:0]); cur_order = v[8]; cur_cshi = v[9]; cur_inv = v[10];
      cur_mode = v[11]; cur_stream = v[12]; cur_en = v[13]; cur_ien = v[14];
      cur_route = v[15];
      @(negedge clk);
   endtask

   task automatic xfer(input logic [7:0] tx, input logic [7:0] sb, input bit inj);
      int p, tot;
      bit bad_busy, bad_irq, bad_cs, bad_oth;
      p = (cur_p == 0) ? 1 : cur_p;
      tot = 17 * p;
      bad_busy = 0; bad_irq = 0; bad_cs = 0; bad_oth = 0;
      @(posedge clk);
      s_tx = sb; s_clr = 1'b1;
      @(negedge clk);
      dat_we = 1'b1; dat_wdata = tx;
      @(posedge clk);
      s_clr = 1'b0;
      @(negedge clk);
      dat_we = 1'b0;
      for (int j = 0; j <= tot; j++) begin
         if (j > 0) @(negedge clk);
         if (inj && j == 2) begin dat_we = 1'b1; dat_wdata = ~tx; end
         if (inj && j == 3) dat_we = 1'b0;
         if (busy !== (j < tot)) bad_busy = 1;
         if (irq !== ((j == tot) && cur_ien)) bad_irq = 1;
         if (j < tot && sel_cs !== cur_cshi) bad_cs = 1;
         if (oth_cs !== !cur_cshi || oth_sclk !== cur_inv || oth_mosi !== 1'b0) bad_oth = 1;
      end
      chk(!bad_busy, "R2", "busy window", int'(bad_busy), 0);
      chk(!bad_irq, "R10", "irq pulse", int'(bad_irq), 0);
      chk(!bad_cs, "R6", "chip select active while busy", int'(bad_cs), 0);
      chk(!bad_oth, "R11", "unselected port idle", int'(bad_oth), 0);
      chk(s_lead == 8 && s_trail == 8, "R5", "edge count lead*16+trail",
          s_lead * 16 + s_trail, 8 * 16 + 8);
      chk(sel_sclk === cur_inv, "R5", "clock idle after byte", int'(sel_sclk), int'(cur_inv));
      chk(dat_rdata === sb, "R3 R4", "received byte", int'(dat_rdata), int'(sb));
      chk(s_rx === tx, "R3 R8", "byte seen by slave", int'(s_rx), int'(tx));
      chk(sel_cs === (cur_stream ? cur_cshi : !cur_cshi), "R7", "chip select after byte",
          int'(sel_cs), int'(cur_stream ? cur_cshi : !cur_cshi));
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      chk(0, "ALL", "watchdog expired", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk(cfg_rdata === 16'h0002, "R1", "config reset value", int'(cfg_rdata), 2);
      chk(busy === 1'b0 && irq === 1'b0, "R1", "busy/irq at reset", int'({busy, irq}), 0);
      chk(ext_cs === 1'b1 && int_cs === 1'b1, "R1", "cs pins inactive",
          int'({ext_cs, int_cs}), 3);
      chk({ext_sclk, int_sclk, ext_mosi, int_mosi} === 4'b0, "R1", "clock and data low",
          int'({ext_sclk, int_sclk, ext_mosi, int_mosi}), 0);

      // sweep: divider 0..3 against order, cs sense, clock sense, edge mode, port
      for (int pr = 0; pr < 4; pr++) begin
         for (int b = 0; b < 32; b++) begin
            logic [15:0] v;
            v = 16'h6000 | 16'(pr) | (16'(b & 1) << 8) | (16'((b >> 1) & 1) << 9)
                | (16'((b >> 2) & 1) << 10) | (16'((b >> 3) & 1) << 11)
                | (16'((b >> 4) & 1) << 15);
            set_cfg(v);
            if (pr == 3 && b == 31)
               chk(cfg_rdata === v, "R1", "config readback", int'(cfg_rdata), int'(v));
            xfer(8'(8'hA5 ^ (pr * 37 + b * 11)), 8'(8'h3C + b * 7 + pr * 13), 1'b0);
         end
      end

      // R7 stream mode keeps chip select across bytes
      set_cfg(16'h7002);
      xfer(8'h81, 8'h42, 1'b0);
      begin
         bit gap_bad;
         gap_bad = 0;
         repeat (6) begin
            @(negedge clk);
            if (ext_cs !== 1'b0) gap_bad = 1;
         end
         chk(!gap_bad, "R7", "chip select held between stream bytes", int'(gap_bad), 0);
      end
      xfer(8'h7E, 8'h99, 1'b0);
      set_cfg(16'h6002);
      chk(ext_cs === 1'b1, "R7", "chip select released on stream clear", int'(ext_cs), 1);

      // R10 no interrupt when disabled
      set_cfg(16'h2003);
      xfer(8'h11, 8'h22, 1'b0);

      // R8 write during a byte is ignored
      set_cfg(16'h6002);
      xfer(8'h5A, 8'h3C, 1'b1);

      // R9 write with the master disabled
      set_cfg(16'h4002);
      @(negedge clk);
      dat_we = 1'b1; dat_wdata = 8'hF0;
      @(negedge clk);
      dat_we = 1'b0;
      chk(busy === 1'b0 && ext_cs === 1'b1, "R9", "disabled write starts nothing",
          int'({busy, ext_cs}), 1);

      // R9 abort by clearing enable mid-byte
      set_cfg(16'h6004);
      @(negedge clk);
      dat_we = 1'b1; dat_wdata = 8'h0F;
      @(negedge clk);
      dat_we = 1'b0;
      repeat (5) @(negedge clk);
      chk(busy === 1'b1, "R9", "byte running before abort", int'(busy), 1);
      set_cfg(16'h4004);
      chk(busy === 1'b0 && ext_cs === 1'b1, "R9", "abort stops byte",
          int'({busy, ext_cs}), 1);
      begin
         bit irq_seen;
         irq_seen = 0;
         repeat (80) begin
            @(negedge clk);
            if (irq !== 1'b0 || busy !== 1'b0) irq_seen = 1;
         end
         chk(!irq_seen, "R9", "no irq or restart after abort", int'(irq_seen), 0);
      end

      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
   end

endmodule